// File: doc/BRIEF.md
# Sixty-Degree Grid Nearest-Triangle Locator

This block turns one sample of a rotating voltage reference into the data needed for a space-vector modulation period of a multilevel inverter. Each sample is a modulation index and a phase angle, marked by a valid strobe. The block folds the angle into the first 60-degree sector and reports which sector it came from. It then expresses the reference on two integer axes 60 degrees apart, in units of one cell DC voltage. On these axes every grid point is a space vector.

The integer parts of the two coordinates select a rhombus of the grid. One comparison of the summed fractional parts splits that rhombus into its lower or upper triangle. The block outputs the three triangle corners and three dwell counts that fill the modulation period exactly. A reference beyond the hexagon edge is pulled back onto it. The datapath is a four-stage pipeline and accepts one sample per clock. Switching-state choice and gate timing are done downstream.

Top module: `vec60_locator`

## Requirements
- R1: `out_valid` rises exactly four clock cycles after each cycle in which `in_valid` is high, and it is low during and after reset until such a result arrives.
- R2: `in_angle` counts in steps of 1/(6·2^SEC_BITS) of a turn. The sector index is `in_angle` divided by 2^SEC_BITS (0 to 5), and the remainder is the position inside the sector. A code of 6·2^SEC_BITS or above is first reduced by 6·2^SEC_BITS.
- R3: `in_mod` is unsigned, with MOD_FRAC fraction bits. With L = LEVELS−1, phi the in-sector angle and g = m·L·2/√3, the axis coordinates are alpha = g·sin(60°−phi) and beta = g·sin(phi). The base corner (a, b) is their integer parts.
- R4: Let fa and fb be the fractional parts. When fa+fb < 1, the corners in order are (a,b), (a+1,b), (a,b+1). Otherwise they are (a+1,b+1), (a+1,b), (a,b+1).
- R5: For the lower triangle, `out_t1` and `out_t2` are floor(fa·PERIOD) and floor(fb·PERIOD). For the upper triangle they are floor((1−fb)·PERIOD) and floor((1−fa)·PERIOD).
- R6: `out_t0` is PERIOD minus the other two counts, so the three counts always sum to PERIOD.
- R7: If alpha+beta reaches L or more, the sum is cut to L minus one LSB. Half the excess, rounded down, comes off alpha and the rest comes off beta. If beta is smaller than its share, the result is (L−1LSB, 0). If alpha is smaller than its share, the result is (0, L−1LSB). Every reported corner then has a+b ≤ L.
- R8: Samples given on consecutive cycles each produce a result, in the same order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_mod | input | MOD_FRAC+1 | Modulation index, unsigned fixed point |
| in_angle | input | SEC_BITS+3 | Phase angle code |
| out_valid | output | 1 | Result strobe |
| out_sector | output | 3 | Sector index 0..5 |
| out_v0_a | output | clog2(LEVELS) | Corner 0, alpha axis |
| out_v0_b | output | clog2(LEVELS) | Corner 0, beta axis |
| out_v1_a | output | clog2(LEVELS) | Corner 1, alpha axis |
| out_v1_b | output | clog2(LEVELS) | Corner 1, beta axis |
| out_v2_a | output | clog2(LEVELS) | Corner 2, alpha axis |
| out_v2_b | output | clog2(LEVELS) | Corner 2, beta axis |
| out_t0 | output | clog2(PERIOD+1) | Dwell count for corner 0 |
| out_t1 | output | clog2(PERIOD+1) | Dwell count for corner 1 |
| out_t2 | output | clog2(PERIOD+1) | Dwell count for corner 2 |

## Verification
All results of a sample (sector, corners and counts) are due together. They appear four rising edges after the edge that takes in the strobe. Stimulus is applied on falling edges and results are read on the fourth falling edge that follows. The third falling edge is checked to show no valid, which fixes the latency exactly. The streaming test reads sample i at falling edge i+4 while it is still driving later samples.

// File: rtl/vec60_pkg.sv
package vec60_pkg;

    typedef logic [2:0] sector_t;

    typedef enum logic {
        TRI_LOW  = 1'b0,
        TRI_HIGH = 1'b1
    } tri_e;

    // (2/sqrt3)*sin(idx/2^sec_bits * 60deg) scaled by 2^gfrac, rounded
    function automatic int gain_entry(input int idx, input int sec_bits, input int gfrac);
        real x;
        real x2;
        real term;
        real s;
        x    = 1.0471975511965976 * real'(idx) / real'(1 << sec_bits);
        x2   = x * x;
        term = x;
        s    = x;
        for (int k = 1; k <= 6; k++) begin
            term = -term * x2 / real'((2 * k) * (2 * k + 1));
            s    = s + term;
        end
        return int'(s * 1.1547005383792515 * real'(1 << gfrac));
    endfunction

endpackage

// File: rtl/vec60_fold.sv
module vec60_fold #(
    parameter int SEC_BITS = 8,
    parameter int MW       = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_valid,
    input  logic [MW-1:0]         i_mod,
    input  logic [SEC_BITS+2:0]   i_angle,
    output logic                  o_valid,
    output logic [MW-1:0]         o_mod,
    output logic [SEC_BITS-1:0]   o_pos,
    output vec60_pkg::sector_t    o_sector
);
    localparam int AW = SEC_BITS + 3;
    localparam logic [AW-1:0] TURN = AW'(6 << SEC_BITS);

    logic [AW-1:0] wrapped;

    always_comb begin
        wrapped = (i_angle >= TURN) ? (i_angle - TURN) : i_angle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_mod    <= '0;
            o_pos    <= '0;
            o_sector <= '0;
        end else begin
            o_valid  <= i_valid;
            o_mod    <= i_mod;
            o_pos    <= wrapped[SEC_BITS-1:0];
            o_sector <= wrapped[AW-1:SEC_BITS];
        end
    end
endmodule

// File: rtl/vec60_project.sv
module vec60_project #(
    parameter int SEC_BITS  = 8,
    parameter int MOD_FRAC  = 12,
    parameter int GAIN_FRAC = 14,
    parameter int FRAC      = 12,
    parameter int LEVELS    = 9,
    parameter int CW        = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_valid,
    input  logic [MOD_FRAC:0]     i_mod,
    input  logic [SEC_BITS-1:0]   i_pos,
    input  vec60_pkg::sector_t    i_sector,
    output logic                  o_valid,
    output logic [CW-1:0]         o_alpha,
    output logic [CW-1:0]         o_beta,
    output vec60_pkg::sector_t    o_sector
);
    localparam int MW = MOD_FRAC + 1;
    localparam int GW = GAIN_FRAC + 1;
    localparam int TN = (1 << SEC_BITS) + 1;
    localparam int IW = SEC_BITS + 1;
    localparam int LW = $clog2(LEVELS);
    localparam int PW = MW + GW + LW;
    localparam int SH = MOD_FRAC + GAIN_FRAC - FRAC;
    localparam logic [LW-1:0] SPAN = LW'(LEVELS - 1);

    logic [GW-1:0] gain_rom [TN];

    for (genvar i = 0; i < TN; i++) begin : g_rom
        assign gain_rom[i] = GW'(vec60_pkg::gain_entry(i, SEC_BITS, GAIN_FRAC));
    end

    logic [IW-1:0] idx_a, idx_b;
    logic [PW-1:0] prod_a, prod_b;

    always_comb begin
        idx_b  = {1'b0, i_pos};
        idx_a  = IW'(1 << SEC_BITS) - idx_b;
        prod_a = PW'(i_mod) * PW'(gain_rom[idx_a]) * PW'(SPAN);
        prod_b = PW'(i_mod) * PW'(gain_rom[idx_b]) * PW'(SPAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_alpha  <= '0;
            o_beta   <= '0;
            o_sector <= '0;
        end else begin
            o_valid  <= i_valid;
            o_alpha  <= CW'(prod_a >> SH);
            o_beta   <= CW'(prod_b >> SH);
            o_sector <= i_sector;
        end
    end
endmodule

// File: rtl/vec60_clamp.sv
module vec60_clamp #(
    parameter int FRAC   = 12,
    parameter int LEVELS = 9,
    parameter int CW     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               i_valid,
    input  logic [CW-1:0]      i_alpha,
    input  logic [CW-1:0]      i_beta,
    input  vec60_pkg::sector_t i_sector,
    output logic               o_valid,
    output logic [CW-1:0]      o_alpha,
    output logic [CW-1:0]      o_beta,
    output vec60_pkg::sector_t o_sector
);
    localparam int XW = CW + 1;
    localparam logic [XW-1:0] LIM = XW'((LEVELS - 1) * (1 << FRAC) - 1);

    logic [XW-1:0] sum, excess, cut_a, cut_b, wa, wb;
    logic [CW-1:0] na, nb;

    always_comb begin
        wa     = {1'b0, i_alpha};
        wb     = {1'b0, i_beta};
        sum    = wa + wb;
        excess = sum - LIM;
        cut_a  = excess >> 1;
        cut_b  = excess - cut_a;
        na     = i_alpha;
        nb     = i_beta;
        if (sum > LIM) begin
            if (wb < cut_b) begin
                na = CW'(LIM);
                nb = '0;
            end else if (wa < cut_a) begin
                na = '0;
                nb = CW'(LIM);
            end else begin
                na = CW'(wa - cut_a);
                nb = CW'(wb - cut_b);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_alpha  <= '0;
            o_beta   <= '0;
            o_sector <= '0;
        end else begin
            o_valid  <= i_valid;
            o_alpha  <= na;
            o_beta   <= nb;
            o_sector <= i_sector;
        end
    end
endmodule

// File: rtl/vec60_triangle.sv
module vec60_triangle #(
    parameter int FRAC   = 12,
    parameter int PERIOD = 1000,
    parameter int CW     = 16,
    parameter int VW     = 4,
    parameter int DW     = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               i_valid,
    input  logic [CW-1:0]      i_alpha,
    input  logic [CW-1:0]      i_beta,
    input  vec60_pkg::sector_t i_sector,
    output logic               o_valid,
    output vec60_pkg::sector_t o_sector,
    output logic [VW-1:0]      o_v0_a,
    output logic [VW-1:0]      o_v0_b,
    output logic [VW-1:0]      o_v1_a,
    output logic [VW-1:0]      o_v1_b,
    output logic [VW-1:0]      o_v2_a,
    output logic [VW-1:0]      o_v2_b,
    output logic [DW-1:0]      o_t0,
    output logic [DW-1:0]      o_t1,
    output logic [DW-1:0]      o_t2
);
    import vec60_pkg::*;

    localparam int IB  = CW - FRAC;
    localparam int MPW = FRAC + 1 + DW;
    localparam logic [FRAC:0] ONE = (FRAC + 1)'(1 << FRAC);

    logic [IB-1:0]   ia, ib;
    logic [FRAC-1:0] fa, fb;
    logic [FRAC:0]   fsum, w1, w2;
    logic [MPW-1:0]  m1, m2;
    logic [DW-1:0]   d1, d2;
    logic [VW-1:0]   base_a, base_b;
    tri_e            shape;

    always_comb begin
        {ia, fa} = i_alpha;
        {ib, fb} = i_beta;
        base_a   = VW'(ia);
        base_b   = VW'(ib);
        fsum     = {1'b0, fa} + {1'b0, fb};
        shape    = fsum[FRAC] ? TRI_HIGH : TRI_LOW;
        if (shape == TRI_HIGH) begin
            w1 = ONE - {1'b0, fb};
            w2 = ONE - {1'b0, fa};
        end else begin
            w1 = {1'b0, fa};
            w2 = {1'b0, fb};
        end
        m1 = MPW'(w1) * MPW'(PERIOD);
        m2 = MPW'(w2) * MPW'(PERIOD);
        d1 = DW'(m1 >> FRAC);
        d2 = DW'(m2 >> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_sector <= '0;
            o_v0_a   <= '0;
            o_v0_b   <= '0;
            o_v1_a   <= '0;
            o_v1_b   <= '0;
            o_v2_a   <= '0;
            o_v2_b   <= '0;
            o_t0     <= '0;
            o_t1     <= '0;
            o_t2     <= '0;
        end else begin
            o_valid  <= i_valid;
            o_sector <= i_sector;
            o_v0_a   <= (shape == TRI_HIGH) ? base_a + 1'b1 : base_a;
            o_v0_b   <= (shape == TRI_HIGH) ? base_b + 1'b1 : base_b;
            o_v1_a   <= base_a + 1'b1;
            o_v1_b   <= base_b;
            o_v2_a   <= base_a;
            o_v2_b   <= base_b + 1'b1;
            o_t1     <= d1;
            o_t2     <= d2;
            o_t0     <= DW'(PERIOD) - d1 - d2;
        end
    end
endmodule

// File: rtl/vec60_locator.sv
module vec60_locator #(
    parameter int LEVELS    = 9,
    parameter int SEC_BITS  = 8,
    parameter int MOD_FRAC  = 12,
    parameter int GAIN_FRAC = 14,
    parameter int FRAC      = 12,
    parameter int PERIOD    = 1000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [MOD_FRAC:0]             in_mod,
    input  logic [SEC_BITS+2:0]           in_angle,
    output logic                          out_valid,
    output logic [2:0]                    out_sector,
    output logic [$clog2(LEVELS)-1:0]     out_v0_a,
    output logic [$clog2(LEVELS)-1:0]     out_v0_b,
    output logic [$clog2(LEVELS)-1:0]     out_v1_a,
    output logic [$clog2(LEVELS)-1:0]     out_v1_b,
    output logic [$clog2(LEVELS)-1:0]     out_v2_a,
    output logic [$clog2(LEVELS)-1:0]     out_v2_b,
    output logic [$clog2(PERIOD+1)-1:0]   out_t0,
    output logic [$clog2(PERIOD+1)-1:0]   out_t1,
    output logic [$clog2(PERIOD+1)-1:0]   out_t2
);
    import vec60_pkg::*;

    localparam int MW = MOD_FRAC + 1;
    localparam int CW = FRAC + $clog2(2 * (LEVELS - 1));
    localparam int VW = $clog2(LEVELS);
    localparam int DW = $clog2(PERIOD + 1);

    logic                s1_valid, s2_valid, s3_valid;
    logic [MW-1:0]       s1_mod;
    logic [SEC_BITS-1:0] s1_pos;
    sector_t             s1_sector, s2_sector, s3_sector;
    logic [CW-1:0]       s2_alpha, s2_beta, s3_alpha, s3_beta;

    vec60_fold #(.SEC_BITS(SEC_BITS), .MW(MW)) u_fold (
        .clk(clk), .rst(rst),
        .i_valid(in_valid), .i_mod(in_mod), .i_angle(in_angle),
        .o_valid(s1_valid), .o_mod(s1_mod), .o_pos(s1_pos), .o_sector(s1_sector)
    );

    vec60_project #(
        .SEC_BITS(SEC_BITS), .MOD_FRAC(MOD_FRAC), .GAIN_FRAC(GAIN_FRAC),
        .FRAC(FRAC), .LEVELS(LEVELS), .CW(CW)
    ) u_project (
        .clk(clk), .rst(rst),
        .i_valid(s1_valid), .i_mod(s1_mod), .i_pos(s1_pos), .i_sector(s1_sector),
        .o_valid(s2_valid), .o_alpha(s2_alpha), .o_beta(s2_beta), .o_sector(s2_sector)
    );

    vec60_clamp #(.FRAC(FRAC), .LEVELS(LEVELS), .CW(CW)) u_clamp (
        .clk(clk), .rst(rst),
        .i_valid(s2_valid), .i_alpha(s2_alpha), .i_beta(s2_beta), .i_sector(s2_sector),
        .o_valid(s3_valid), .o_alpha(s3_alpha), .o_beta(s3_beta), .o_sector(s3_sector)
    );

    vec60_triangle #(
        .FRAC(FRAC), .PERIOD(PERIOD), .CW(CW), .VW(VW), .DW(DW)
    ) u_triangle (
        .clk(clk), .rst(rst),
        .i_valid(s3_valid), .i_alpha(s3_alpha), .i_beta(s3_beta), .i_sector(s3_sector),
        .o_valid(out_valid), .o_sector(out_sector),
        .o_v0_a(out_v0_a), .o_v0_b(out_v0_b),
        .o_v1_a(out_v1_a), .o_v1_b(out_v1_b),
        .o_v2_a(out_v2_a), .o_v2_b(out_v2_b),
        .o_t0(out_t0), .o_t1(out_t1), .o_t2(out_t2)
    );
endmodule

// File: rtl/vec60_checks.sv
module vec60_checks #(
    parameter int LEVELS = 9,
    parameter int PERIOD = 1000
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        out_valid,
    input logic [2:0]                  out_sector,
    input logic [$clog2(LEVELS)-1:0]   out_v0_a,
    input logic [$clog2(LEVELS)-1:0]   out_v0_b,
    input logic [$clog2(LEVELS)-1:0]   out_v1_a,
    input logic [$clog2(LEVELS)-1:0]   out_v1_b,
    input logic [$clog2(LEVELS)-1:0]   out_v2_a,
    input logic [$clog2(LEVELS)-1:0]   out_v2_b,
    input logic [$clog2(PERIOD+1)-1:0] out_t0,
    input logic [$clog2(PERIOD+1)-1:0] out_t1,
    input logic [$clog2(PERIOD+1)-1:0] out_t2
);
    logic [3:0] strobe_hist;

    always_ff @(posedge clk) begin
        if (rst) strobe_hist <= '0;
        else     strobe_hist <= {strobe_hist[2:0], in_valid};
    end

    // R1 and R8: every strobe returns exactly four cycles later
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == strobe_hist[3]);

    a_r2_sector_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sector < 3'd6));

    a_r4_corner_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_v1_a == out_v2_a + 1'b1) && (out_v2_b == out_v1_b + 1'b1) &&
                       (((out_v0_a == out_v2_a) && (out_v0_b == out_v1_b)) ||
                        ((out_v0_a == out_v1_a) && (out_v0_b == out_v2_b)))));

    a_r6_fills_period: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_t0) + int'(out_t1) + int'(out_t2) == PERIOD));

    a_r7_inside_hex: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((int'(out_v0_a) + int'(out_v0_b) <= LEVELS - 1) &&
                       (int'(out_v1_a) + int'(out_v1_b) <= LEVELS - 1) &&
                       (int'(out_v2_a) + int'(out_v2_b) <= LEVELS - 1)));
endmodule

bind vec60_locator vec60_checks #(.LEVELS(LEVELS), .PERIOD(PERIOD)) u_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_sector(out_sector),
    .out_v0_a(out_v0_a), .out_v0_b(out_v0_b),
    .out_v1_a(out_v1_a), .out_v1_b(out_v1_b),
    .out_v2_a(out_v2_a), .out_v2_b(out_v2_b),
    .out_t0(out_t0), .out_t1(out_t1), .out_t2(out_t2)
);

// File: tb/vec60_locator_bench.sv
`timescale 1ns/1ps
module vec60_locator_bench;
    localparam int LEVELS = 9;
    localparam int SB     = 8;
    localparam int MF     = 12;
    localparam int PERIOD = 1000;
    localparam int VW     = $clog2(LEVELS);
    localparam int DW     = $clog2(PERIOD + 1);
    localparam real PI    = 3.141592653589793;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [MF:0]   in_mod = '0;
    logic [SB+2:0] in_angle = '0;
    logic out_valid;
    logic [2:0] out_sector;
    logic [VW-1:0] v0a, v0b, v1a, v1b, v2a, v2b;
    logic [DW-1:0] t0, t1, t2;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vec60_locator #(.LEVELS(LEVELS), .SEC_BITS(SB), .MOD_FRAC(MF), .PERIOD(PERIOD)) u_vec60_locator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mod(in_mod), .in_angle(in_angle),
        .out_valid(out_valid), .out_sector(out_sector),
        .out_v0_a(v0a), .out_v0_b(v0b), .out_v1_a(v1a), .out_v1_b(v1b),
        .out_v2_a(v2a), .out_v2_b(v2b), .out_t0(t0), .out_t1(t1), .out_t2(t2)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare the output registers with an expected result
    task automatic compare(input string tag, input int sec, input int ev[6], input int et[3], input int tol);
        int got_v[6];
        int got_t[3];
        got_v = '{int'(v0a), int'(v0b), int'(v1a), int'(v1b), int'(v2a), int'(v2b)};
        got_t = '{int'(t0), int'(t1), int'(t2)};
        check(out_valid == 1'b1, {tag, " R1 valid"}, int'(out_valid), 1);
        check(int'(out_sector) == sec, {tag, " R2 sector"}, int'(out_sector), sec);
        for (int i = 0; i < 6; i++)
            check(got_v[i] == ev[i], $sformatf("%s R4 corner coord %0d", tag, i), got_v[i], ev[i]);
        for (int i = 0; i < 3; i++) begin
            int d = got_t[i] - et[i];
            check(d <= tol && d >= -tol, $sformatf("%s R5 dwell %0d", tag, i), got_t[i], et[i]);
        end
        check(got_t[0] + got_t[1] + got_t[2] == PERIOD, {tag, " R6 period sum"},
              got_t[0] + got_t[1] + got_t[2], PERIOD);
        check(got_v[0] + got_v[1] <= LEVELS - 1 && got_v[2] + got_v[3] <= LEVELS - 1 &&
              got_v[4] + got_v[5] <= LEVELS - 1, {tag, " R7 inside"}, got_v[0] + got_v[1], LEVELS - 1);
    endtask

    // Expected values from the requirement formulas (no clamping)
    task automatic model(input int m, input int ang, output int sec, output int ev[6], output int et[3]);
        int w, a, b;
        real phi, g, al, be, fa, fb;
        w = (ang >= 6 * (1 << SB)) ? ang - 6 * (1 << SB) : ang;
        sec = w >> SB;
        phi = real'(w % (1 << SB)) / real'(1 << SB) * PI / 3.0;
        g  = real'(m) / real'(1 << MF) * real'(LEVELS - 1) * 2.0 / $sqrt(3.0);
        al = g * $sin(PI / 3.0 - phi);
        be = g * $sin(phi);
        a  = int'($floor(al));
        b  = int'($floor(be));
        fa = al - real'(a);
        fb = be - real'(b);
        if (fa + fb < 1.0) begin
            ev = '{a, b, a + 1, b, a, b + 1};
            et[1] = int'($floor(fa * PERIOD));
            et[2] = int'($floor(fb * PERIOD));
        end else begin
            ev = '{a + 1, b + 1, a + 1, b, a, b + 1};
            et[1] = int'($floor((1.0 - fb) * PERIOD));
            et[2] = int'($floor((1.0 - fa) * PERIOD));
        end
        et[0] = PERIOD - et[1] - et[2];
    endtask

    // One sample; result read on the fourth falling edge after the strobe edge
    task automatic issue(input int m, input int ang);
        @(negedge clk);
        in_valid = 1'b1;
        in_mod   = (MF + 1)'(m);
        in_angle = (SB + 3)'(ang);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 no early result", int'(out_valid), 0);
        @(negedge clk);
    endtask

    task automatic test_reset();
        check(out_valid == 1'b0, "R1 reset clears valid", int'(out_valid), 0);
    endtask

    task automatic test_model_point(input string tag, input int m, input int ang);
        int sec;
        int ev[6];
        int et[3];
        model(m, ang, sec, ev, et);
        issue(m, ang);
        compare(tag, sec, ev, et, 3);
    endtask

    task automatic test_exact(input string tag, input int m, input int ang, input int sec,
                              input int ev[6], input int et[3]);
        issue(m, ang);
        compare(tag, sec, ev, et, 0);
    endtask

    task automatic test_sectors();
        for (int k = 0; k < 6; k++)
            test_model_point($sformatf("R2 R3 sector %0d", k), 2458, k * 256 + 128);
    endtask

    task automatic test_stream();
        int sec;
        int ev[6];
        int et[3];
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (i >= 4 && i < 10) begin
                model(2458, (i - 4) * 256 + 128, sec, ev, et);
                compare($sformatf("R8 stream item %0d", i - 4), sec, ev, et, 3);
            end
            if (i == 10)
                check(out_valid == 1'b0, "R8 stream ends", int'(out_valid), 0);
            if (i < 6) begin
                in_valid = 1'b1;
                in_mod   = (MF + 1)'(2458);
                in_angle = (SB + 3)'(i * 256 + 128);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_exact("R3 zero index", 0, 0, 0, '{0, 0, 1, 0, 0, 1}, '{1000, 0, 0});
        test_exact("R3 half index on axis", 2048, 0, 0, '{4, 0, 5, 0, 4, 1}, '{1000, 0, 0});
        test_sectors();
        test_model_point("R2 wrapped code", 2458, 1664);
        test_model_point("R2 top code", 2458, 2047);
        test_model_point("R4 lower triangle", 2253, 192);
        test_model_point("R4 R5 upper triangle", 1229, 64);
        test_exact("R7 clamp on axis", 6144, 0, 0, '{7, 0, 8, 0, 7, 1}, '{1, 999, 0});
        test_exact("R7 clamp mid sector", 6144, 128, 0, '{4, 3, 5, 3, 4, 4}, '{1, 0, 999});
        test_stream();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule